// File: doc/BRIEF.md
# Waveform Scenario Sequencer with Selectable Jump Policies

The sequencer walks a small internal table of waveform descriptors and, in every sync-clock cycle, emits the waveform identifier and the sample index within it that a downstream sample memory should read. Each table entry names a waveform, its length in samples, how many times it repeats, and whether it closes a scenario. A scenario is the run of consecutive entries that starts at some entry and ends at the first entry carrying the closing flag. When a scenario ends and nothing else is requested, the sequencer returns to that scenario's first entry.

Jumps to another scenario are requested either by a trigger pulse, which uses a target held on a separate address input, or by a strobe on a 13-bit dynamic address port. A policy input chooses when a pending jump is taken: after a fixed latency, at the end of the current waveform after all its repeats, or at the end of the current scenario. The jump never adds a gap or a repeated cycle in the output stream. The table is loaded through a simple write port before playback.

Top module: `wave_scn_seq`

## Requirements
- R1: After reset, out_valid is 0, out_seg is 0 and out_sample is 0, and they stay so until the first jump request.
- R2: A descriptor entry holds waveform id, length minus one L, repeat count minus one P and a closing flag; playback emits samples 0..L of that waveform, plays this P+1 times, then moves to the next entry, the index after the highest one being 0.
- R3: When the last sample of the last repeat of a closing entry is emitted and no jump is taken there, the next cycle emits sample 0 of the first entry of the current scenario.
- R4: With jump_mode = 0 (immediate), sample 0 of the target's first entry appears on the outputs exactly LAT cycles after the clock edge that samples the request, cutting the current waveform.
- R5: With jump_mode = 1 (end of waveform), the jump is taken at the first cycle, no earlier than LAT cycles after the request, that emits the last sample of the last repeat of the current entry.
- R6: With jump_mode = 2 or 3 (end of scenario), the jump is taken at the first cycle, no earlier than LAT cycles after the request, that ends the current scenario, so the latency is the longer of LAT and the remaining scenario time.
- R7: A request while another is pending replaces the pending target and restarts the LAT count; a request sampled in the same edge that takes a pending jump becomes the next pending jump.
- R8: dyn_stb requests a jump to dyn_addr and trig to trig_addr; if both are high in one cycle dyn_addr wins; only the low IDX_W bits of the 13-bit address select the entry.
- R9: A request while idle starts playback LAT cycles after its sampling edge in every mode, and from then on out_valid stays 1 in every cycle, including across jumps.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sync clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| wr_en | input | 1 | Descriptor write strobe |
| wr_idx | input | IDX_W | Descriptor entry to write |
| wr_seg | input | SEG_W | Waveform id for the entry |
| wr_len_m1 | input | LEN_W | Waveform length minus one |
| wr_rep_m1 | input | REP_W | Repeat count minus one |
| wr_last | input | 1 | Entry closes its scenario |
| jump_mode | input | 2 | 0 immediate, 1 end of waveform, 2 or 3 end of scenario |
| trig | input | 1 | Jump trigger pulse |
| trig_addr | input | ADDR_W | Target scenario start used by trig |
| dyn_stb | input | 1 | Dynamic jump strobe |
| dyn_addr | input | ADDR_W | Dynamic target scenario start |
| out_valid | output | 1 | A sample address is being emitted |
| out_seg | output | SEG_W | Current waveform id (0 when idle) |
| out_sample | output | LEN_W | Sample index within the waveform |

## Verification
Two things can coincide in one cycle: a trigger and a dynamic strobe both asserted, and a new request landing on the very edge where an earlier pending jump fires. The bench drives both deliberately: trigger and strobe together with different targets, and a second strobe timed LAT cycles after the first so it is sampled at the firing edge. A behavioural reference model, built on countdowns and integer counters, predicts every cycle's outputs and is compared each clock, so the order of resolution (strobe beats trigger, fired jump completes while the new one stays pending) is judged cycle by cycle together with directed latency counts.

// File: rtl/wss_pkg.sv
package wss_pkg;
  typedef enum logic [1:0] {
    JM_NOW      = 2'd0,
    JM_WAVE     = 2'd1,
    JM_SCEN     = 2'd2,
    JM_SCEN_ALT = 2'd3
  } jmode_e;
endpackage

// File: rtl/wss_rst_sync.sv
module wss_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic srst_n
);
  logic meta_q, hold_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= 1'b0;
      hold_q <= 1'b0;
    end else begin
      meta_q <= 1'b1;
      hold_q <= meta_q;
    end
  end

  assign srst_n = hold_q;
endmodule

// File: rtl/wss_desc_tbl.sv
module wss_desc_tbl #(
  parameter int IDX_W = 5,
  parameter int SEG_W = 8,
  parameter int LEN_W = 8,
  parameter int REP_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [IDX_W-1:0] wr_idx,
  input  logic [SEG_W-1:0] wr_seg,
  input  logic [LEN_W-1:0] wr_len_m1,
  input  logic [REP_W-1:0] wr_rep_m1,
  input  logic             wr_last,
  input  logic [IDX_W-1:0] rd_idx,
  output logic [SEG_W-1:0] rd_seg,
  output logic [LEN_W-1:0] rd_len_m1,
  output logic [REP_W-1:0] rd_rep_m1,
  output logic             rd_last
);
  localparam int DEPTH = 1 << IDX_W;
  localparam int ENT_W = SEG_W + LEN_W + REP_W + 1;

  logic [ENT_W-1:0] ent_q [DEPTH];
  logic [ENT_W-1:0] wr_word;
  logic [DEPTH-1:0] ent_we;

  assign wr_word = {wr_last, wr_rep_m1, wr_len_m1, wr_seg};

  for (genvar g = 0; g < DEPTH; g++) begin : g_ent
    assign ent_we[g] = wr_en && (wr_idx == IDX_W'(g));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        ent_q[g] <= '0;
      end else if (ent_we[g]) begin
        ent_q[g] <= wr_word;
      end
    end
  end

  assign {rd_last, rd_rep_m1, rd_len_m1, rd_seg} = ent_q[rd_idx];

  // R2: a written descriptor is readable from the next cycle on
  a_r2_write_lands: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> ent_q[$past(wr_idx)] == $past(wr_word));
endmodule

// File: rtl/wss_jump_ctrl.sv
module wss_jump_ctrl #(
  parameter int IDX_W = 5,
  parameter int LAT   = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             trig,
  input  logic [IDX_W-1:0] trig_idx,
  input  logic             dyn_stb,
  input  logic [IDX_W-1:0] dyn_idx,
  input  logic             take,
  output logic             ripe,
  output logic [IDX_W-1:0] tgt_idx
);
  localparam int AGE_W = $clog2(LAT + 1);
  localparam logic [AGE_W-1:0] AGE_MAX = AGE_W'(LAT);
  localparam logic [AGE_W-1:0] AGE_ONE = AGE_W'(1);

  logic             pend_q, pend_d;
  logic [IDX_W-1:0] tgt_q, tgt_d;
  logic [AGE_W-1:0] age_q, age_d;
  logic             req;

  assign req = trig | dyn_stb;

  always_comb begin
    pend_d = pend_q;
    tgt_d  = tgt_q;
    age_d  = age_q;
    if (req) begin
      pend_d = 1'b1;
      tgt_d  = dyn_stb ? dyn_idx : trig_idx;
      age_d  = AGE_ONE;
    end else if (take) begin
      pend_d = 1'b0;
      age_d  = '0;
    end else if (pend_q && (age_q != AGE_MAX)) begin
      age_d  = age_q + AGE_ONE;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q <= 1'b0;
      tgt_q  <= '0;
      age_q  <= '0;
    end else begin
      pend_q <= pend_d;
      tgt_q  <= tgt_d;
      age_q  <= age_d;
    end
  end

  assign ripe    = pend_q && (age_q == AGE_MAX);
  assign tgt_idx = tgt_q;

  // R8: strobe target beats trigger target
  a_r8_dyn_wins: assert property (@(posedge clk) disable iff (!rst_n)
    (trig && dyn_stb) |=> (pend_q && tgt_q == $past(dyn_idx)));
  // R4: the walker never takes a jump before the latency has elapsed
  a_r4_no_early_take: assert property (@(posedge clk) disable iff (!rst_n)
    take |-> (pend_q && age_q == AGE_MAX));
  // R7: a taken jump is retired unless a new request arrives with it
  a_r7_take_retires: assert property (@(posedge clk) disable iff (!rst_n)
    (take && !req) |=> !pend_q);
endmodule

// File: rtl/wss_walk.sv
module wss_walk
  import wss_pkg::*;
#(
  parameter int IDX_W = 5,
  parameter int LEN_W = 8,
  parameter int REP_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [1:0]       mode,
  input  logic             ripe,
  input  logic [IDX_W-1:0] tgt_idx,
  input  logic [LEN_W-1:0] ent_len_m1,
  input  logic [REP_W-1:0] ent_rep_m1,
  input  logic             ent_last,
  output logic             take,
  output logic             act,
  output logic [IDX_W-1:0] ptr,
  output logic [LEN_W-1:0] smp
);
  logic             act_q, act_d;
  logic [IDX_W-1:0] ptr_q, ptr_d, base_q, base_d;
  logic [LEN_W-1:0] smp_q, smp_d;
  logic [REP_W-1:0] rep_q, rep_d;
  logic             seg_end, scn_end, bnd, step_en;

  always_comb begin
    seg_end = (smp_q == ent_len_m1) && (rep_q == ent_rep_m1);
    scn_end = seg_end && ent_last;
    if (mode == JM_NOW)       bnd = 1'b1;
    else if (mode == JM_WAVE) bnd = seg_end;
    else                      bnd = scn_end;
    take    = ripe && (!act_q || bnd);
    step_en = take || act_q;

    act_d  = act_q;
    ptr_d  = ptr_q;
    base_d = base_q;
    smp_d  = smp_q;
    rep_d  = rep_q;
    if (take) begin
      act_d  = 1'b1;
      ptr_d  = tgt_idx;
      base_d = tgt_idx;
      smp_d  = '0;
      rep_d  = '0;
    end else if (smp_q != ent_len_m1) begin
      smp_d = smp_q + 1'b1;
    end else begin
      smp_d = '0;
      if (rep_q != ent_rep_m1) begin
        rep_d = rep_q + 1'b1;
      end else begin
        rep_d = '0;
        ptr_d = ent_last ? base_q : ptr_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_q  <= 1'b0;
      ptr_q  <= '0;
      base_q <= '0;
      smp_q  <= '0;
      rep_q  <= '0;
    end else if (step_en) begin
      act_q  <= act_d;
      ptr_q  <= ptr_d;
      base_q <= base_d;
      smp_q  <= smp_d;
      rep_q  <= rep_d;
    end
  end

  assign act = act_q;
  assign ptr = ptr_q;
  assign smp = smp_q;

  // R9: once started the stream has no gap cycle
  a_r9_no_gap: assert property (@(posedge clk) disable iff (!rst_n)
    act_q |=> act_q);
  // R4: a taken jump lands on sample 0, first repeat, of the target entry
  a_r4_lands_clean: assert property (@(posedge clk) disable iff (!rst_n)
    take |=> (act_q && smp_q == '0 && rep_q == '0 && ptr_q == $past(tgt_idx)));
  // R3: the end of a scenario returns to its first entry
  a_r3_loop_back: assert property (@(posedge clk) disable iff (!rst_n)
    (act_q && !take && scn_end) |=> (ptr_q == $past(base_q) && smp_q == '0));
  // R2: inside a waveform the sample index counts up by one
  a_r2_sample_step: assert property (@(posedge clk) disable iff (!rst_n)
    (act_q && !take && smp_q != ent_len_m1) |=> smp_q == LEN_W'($past(smp_q) + 1'b1));
  // R6: an end-of-scenario jump from a running stream waits for the scenario end
  a_r6_scen_boundary: assert property (@(posedge clk) disable iff (!rst_n)
    (take && act_q && mode[1]) |-> (smp_q == ent_len_m1 && rep_q == ent_rep_m1 && ent_last));
endmodule

// File: rtl/wave_scn_seq.sv
module wave_scn_seq #(
  parameter int ADDR_W = 13,
  parameter int IDX_W  = 5,
  parameter int SEG_W  = 8,
  parameter int LEN_W  = 8,
  parameter int REP_W  = 4,
  parameter int LAT    = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic [SEG_W-1:0]  wr_seg,
  input  logic [LEN_W-1:0]  wr_len_m1,
  input  logic [REP_W-1:0]  wr_rep_m1,
  input  logic              wr_last,
  input  logic [1:0]        jump_mode,
  input  logic              trig,
  input  logic [ADDR_W-1:0] trig_addr,
  input  logic              dyn_stb,
  input  logic [ADDR_W-1:0] dyn_addr,
  output logic              out_valid,
  output logic [SEG_W-1:0]  out_seg,
  output logic [LEN_W-1:0]  out_sample
);
  logic             srst_n;
  logic             take, ripe, act;
  logic [IDX_W-1:0] tgt_idx, ptr;
  logic [SEG_W-1:0] ent_seg;
  logic [LEN_W-1:0] ent_len_m1, smp;
  logic [REP_W-1:0] ent_rep_m1;
  logic             ent_last;
  logic             unused_hi_bits;

  assign unused_hi_bits = ^{trig_addr[ADDR_W-1:IDX_W], dyn_addr[ADDR_W-1:IDX_W]};

  wss_rst_sync u_rst (
    .clk    (clk),
    .rst_n  (rst_n),
    .srst_n (srst_n)
  );

  wss_desc_tbl #(.IDX_W(IDX_W), .SEG_W(SEG_W), .LEN_W(LEN_W), .REP_W(REP_W)) u_tbl (
    .clk       (clk),
    .rst_n     (srst_n),
    .wr_en     (wr_en),
    .wr_idx    (wr_idx),
    .wr_seg    (wr_seg),
    .wr_len_m1 (wr_len_m1),
    .wr_rep_m1 (wr_rep_m1),
    .wr_last   (wr_last),
    .rd_idx    (ptr),
    .rd_seg    (ent_seg),
    .rd_len_m1 (ent_len_m1),
    .rd_rep_m1 (ent_rep_m1),
    .rd_last   (ent_last)
  );

  wss_jump_ctrl #(.IDX_W(IDX_W), .LAT(LAT)) u_jmp (
    .clk      (clk),
    .rst_n    (srst_n),
    .trig     (trig),
    .trig_idx (trig_addr[IDX_W-1:0]),
    .dyn_stb  (dyn_stb),
    .dyn_idx  (dyn_addr[IDX_W-1:0]),
    .take     (take),
    .ripe     (ripe),
    .tgt_idx  (tgt_idx)
  );

  wss_walk #(.IDX_W(IDX_W), .LEN_W(LEN_W), .REP_W(REP_W)) u_walk (
    .clk        (clk),
    .rst_n      (srst_n),
    .mode       (jump_mode),
    .ripe       (ripe),
    .tgt_idx    (tgt_idx),
    .ent_len_m1 (ent_len_m1),
    .ent_rep_m1 (ent_rep_m1),
    .ent_last   (ent_last),
    .take       (take),
    .act        (act),
    .ptr        (ptr),
    .smp        (smp)
  );

  assign out_valid  = act;
  assign out_seg    = act ? ent_seg : '0;
  assign out_sample = smp;
endmodule

// File: tb/sim_wave_scn_seq.sv
module sim_wave_scn_seq;
  localparam int LAT   = 4;
  localparam int DEPTH = 32;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [4:0]  wr_idx = '0;
  logic [7:0]  wr_seg = '0;
  logic [7:0]  wr_len_m1 = '0;
  logic [3:0]  wr_rep_m1 = '0;
  logic        wr_last = 1'b0;
  logic [1:0]  jump_mode = 2'd2;
  logic        trig = 1'b0;
  logic [12:0] trig_addr = '0;
  logic        dyn_stb = 1'b0;
  logic [12:0] dyn_addr = '0;
  logic        out_valid;
  logic [7:0]  out_seg;
  logic [7:0]  out_sample;

  wave_scn_seq #(.LAT(LAT)) u0 (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_idx(wr_idx), .wr_seg(wr_seg),
    .wr_len_m1(wr_len_m1), .wr_rep_m1(wr_rep_m1), .wr_last(wr_last),
    .jump_mode(jump_mode), .trig(trig), .trig_addr(trig_addr),
    .dyn_stb(dyn_stb), .dyn_addr(dyn_addr),
    .out_valid(out_valid), .out_seg(out_seg), .out_sample(out_sample)
  );

  always #5 clk = ~clk;

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  int seen20 = 0;
  string tag = "R1";

  // reference model state
  int  m_seg [DEPTH];
  int  m_len [DEPTH];
  int  m_rep [DEPTH];
  bit  m_last [DEPTH];
  bit  mv;
  int  mp, ms, mr, mb, mtgt, mwait;
  bit  mpend;

  task automatic chk(input bit ok, input string req, input string what,
                     input int act_v, input int exp_v);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act_v, exp_v);
    end
  endtask

  always @(posedge clk) begin
    if (!rst_n) begin
      mv = 0; mp = 0; ms = 0; mr = 0; mb = 0; mpend = 0; mtgt = 0; mwait = 0;
      for (int i = 0; i < DEPTH; i++) begin
        m_seg[i] = 0; m_len[i] = 0; m_rep[i] = 0; m_last[i] = 0;
      end
    end else begin
      bit wave_done, scen_done, edge_ok, fire;
      wave_done = (ms == m_len[mp]) && (mr == m_rep[mp]);
      scen_done = wave_done && m_last[mp];
      edge_ok = (jump_mode == 2'd0) ? 1'b1 : (jump_mode == 2'd1) ? wave_done : scen_done;
      fire = mpend && (mwait == 0) && (!mv || edge_ok);
      if (mpend && !fire && mwait > 0) mwait--;
      if (fire) begin
        mv = 1; mp = mtgt; mb = mtgt; ms = 0; mr = 0; mpend = 0;
      end else if (mv) begin
        if (ms < m_len[mp]) ms++;
        else if (mr < m_rep[mp]) begin ms = 0; mr++; end
        else begin
          ms = 0; mr = 0;
          mp = m_last[mp] ? mb : (mp + 1) % DEPTH;
        end
      end
      if (dyn_stb || trig) begin
        mpend = 1;
        mtgt  = dyn_stb ? int'(dyn_addr) % DEPTH : int'(trig_addr) % DEPTH;
        mwait = LAT - 1;
      end
      if (wr_en) begin
        m_seg[wr_idx] = wr_seg; m_len[wr_idx] = wr_len_m1;
        m_rep[wr_idx] = wr_rep_m1; m_last[wr_idx] = wr_last;
      end
    end
  end

  // cycle-by-cycle comparison against the model (R2, R3 and the current test tag)
  always @(negedge clk) begin
    if (rst_n) begin
      int es;
      bit ok;
      es = mv ? m_seg[mp] : 0;
      ok = (out_valid === mv) && (out_seg === 8'(es)) && (out_sample === 8'(ms));
      chk(ok, tag, "stream valid/seg/sample vs model",
          {out_valid, out_seg, out_sample}, {mv, 8'(es), 8'(ms)});
      if (out_valid && out_seg == 8'd20) seen20++;
    end
  end

  task automatic final_report();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual %0d expected %0d", cycles, 20000);
      final_report();
    end
  end

  task automatic wr(input int idx, input int seg, input int len, input int rep, input bit last);
    wr_en = 1; wr_idx = 5'(idx); wr_seg = 8'(seg); wr_len_m1 = 8'(len);
    wr_rep_m1 = 4'(rep); wr_last = last;
    @(negedge clk);
    wr_en = 0;
  endtask

  task automatic req(input bit t, input bit d, input int ta, input int da);
    trig = t; dyn_stb = d; trig_addr = 13'(ta); dyn_addr = 13'(da);
    @(negedge clk);
    trig = 0; dyn_stb = 0;
  endtask

  // waits until sample 0 of waveform seg; n counts negedges from the drive edge
  task automatic wait_seg(input int seg, output int n, output int pseg,
                          output int psmp, output bit gap);
    int ps, pm;
    n = 1; gap = 0; ps = -1; pm = -1; pseg = -1; psmp = -1;
    while (!(out_valid && out_seg == 8'(seg) && out_sample == 8'd0) && n < 200) begin
      ps = out_seg; pm = out_sample;
      if (!out_valid) gap = 1;
      @(negedge clk);
      n++;
    end
    pseg = ps; psmp = pm;
  endtask

  task automatic idle(input int k);
    for (int i = 0; i < k; i++) @(negedge clk);
  endtask

  initial begin
    int n, ps, pm, s20;
    bit gap;
    repeat (3) @(negedge clk);
    rst_n = 1;
    idle(4);
    // R1: reset state
    tag = "R1";
    chk(out_valid == 0 && out_seg == 0 && out_sample == 0, "R1", "reset outputs",
        {out_valid, out_seg, out_sample}, 0);
    // table: A at 0..1, B at 4..5, C at 8, wrap entry at 31
    wr(0, 10, 2, 1, 0);
    wr(1, 11, 1, 0, 1);
    wr(4, 20, 3, 2, 0);
    wr(5, 21, 0, 1, 1);
    wr(8, 30, 0, 0, 1);
    wr(31, 40, 1, 0, 0);
    idle(5);
    chk(out_valid == 0, "R1", "idle without request", out_valid, 0);

    // R9: start from idle, end-of-scenario mode still uses the fixed latency
    tag = "R9"; jump_mode = 2'd2;
    req(0, 1, 0, 0);
    wait_seg(10, n, ps, pm, gap);
    chk(n == LAT + 1, "R9", "start latency from idle", n - 1, LAT);

    // R2/R3: natural playback and loop back
    tag = "R3";
    n = 0;
    while (!(out_seg == 8'd11 && out_sample == 8'd1) && n < 50) begin @(negedge clk); n++; end
    @(negedge clk);
    chk(out_seg == 8'd10 && out_sample == 0, "R3", "loop to scenario start", out_seg, 10);
    tag = "R2";
    idle(20);

    // R4: immediate jump with fixed latency, no gap
    tag = "R4"; jump_mode = 2'd0;
    req(0, 1, 0, 4);
    wait_seg(20, n, ps, pm, gap);
    chk(n == LAT + 1, "R4", "immediate latency", n - 1, LAT);
    chk(!gap, "R9", "no gap across jump", gap, 0);

    // R5: end-of-waveform jump waits for all repeats of waveform 20
    tag = "R5"; jump_mode = 2'd1;
    idle(2);
    req(1, 0, 8, 0);
    wait_seg(30, n, ps, pm, gap);
    chk(ps == 20 && pm == 3, "R5", "prior sample is end of waveform 20", ps, 20);
    chk(n > LAT + 1, "R5", "latency longer than fixed", n - 1, LAT + 1);

    // R6: end-of-scenario where scenario is 1 cycle: latency equals LAT
    tag = "R6"; jump_mode = 2'd2;
    req(0, 1, 0, 4);
    wait_seg(20, n, ps, pm, gap);
    chk(n == LAT + 1, "R6", "short scenario gives fixed latency", n - 1, LAT);
    // R6: mode 3 waits for the end of scenario B
    jump_mode = 2'd3;
    idle(1);
    req(0, 1, 0, 0);
    wait_seg(10, n, ps, pm, gap);
    chk(ps == 21 && pm == 0, "R6", "prior sample is end of scenario", ps, 21);
    chk(n > LAT + 1, "R6", "remaining scenario dominates", n - 1, LAT + 1);

    // R7: second request replaces first and restarts the count
    tag = "R7"; jump_mode = 2'd0;
    s20 = seen20;
    req(0, 1, 0, 4);
    idle(1);
    req(0, 1, 0, 8);
    wait_seg(30, n, ps, pm, gap);
    chk(n == LAT + 1, "R7", "latency restarts on replacement", n - 1, LAT);
    chk(seen20 == s20, "R7", "replaced target never played", seen20 - s20, 0);

    // R8: strobe beats trigger in the same cycle
    tag = "R8";
    req(1, 1, 0, 4);
    wait_seg(20, n, ps, pm, gap);
    chk(n == LAT + 1, "R8", "dynamic target chosen", n - 1, LAT);
    // R8: upper address bits ignored (0x1FE8 -> entry 8)
    req(0, 1, 0, 13'h1FE8);
    wait_seg(30, n, ps, pm, gap);
    chk(n == LAT + 1, "R8", "low bits select entry", n - 1, LAT);

    // R2: index wraps from the top entry to entry 0
    tag = "R2";
    req(0, 1, 0, 31);
    wait_seg(40, n, ps, pm, gap);
    chk(n == LAT + 1, "R2", "jump to top entry", n - 1, LAT);
    idle(2);
    chk(out_seg == 8'd10 && out_sample == 0, "R2", "wrap to entry 0", out_seg, 10);
    idle(12);

    // R7: request sampled at the edge where the earlier jump fires
    tag = "R7";
    req(0, 1, 0, 4);
    idle(LAT - 1);
    chk(out_seg != 8'd20, "R7", "first jump not yet taken", out_seg, 0);
    req(0, 1, 0, 8);
    chk(out_seg == 8'd20 && out_sample == 0, "R7", "first jump fires", out_seg, 20);
    wait_seg(30, n, ps, pm, gap);
    chk(n == LAT + 1, "R7", "new jump pending after fire", n - 1, LAT);
    chk(!gap, "R9", "no gap through back-to-back jumps", gap, 0);
    idle(10);
    final_report();
  end
endmodule